// File: doc/BRIEF.md
# Serial Peripheral Master with Automatic Device Select

This block connects a simple parallel register bus to up to eight three- or four-wire serial peripherals that use a shared clock/data-out/data-in bus with one active-low select line each. Software places a byte (or two bytes) in the data registers and starts a shift. The block drives the serial clock from a divided copy of its own clock and shifts the data out MSB first. It captures the peripheral's reply into the same registers and then reports completion through a status bit and an optional interrupt.

There are two ways to start a transfer. In the first, software drives the select lines itself through a port register and writes the first byte at its plain address. That transfer takes its bit count and clock polarity from the settings of device 7. In the second, software writes the first byte at one of eight alias addresses, one per device. A sequencer then uses that device's own length and polarity, pulls its select low, runs the shift and releases the select afterwards. This lets each peripheral appear as a memory location.

Top module: `uwire_ctrl`

## Requirements
- R1: After reset the status register (address 0Eh) reads 80h, every select pin is an input (cs_oe = 00h), irq is low, and the length (0Ch) and polarity (0Bh) settings are all zero.
- R2: A write to address 01h while idle starts a transfer that uses bit 7 of the length and polarity registers and drives no select pin. From the next cycle so_out shows the MSB of the word being sent and status bit 7 reads 0.
- R3: A write to address 02h+d (d = 0..7) while idle starts a transfer for device d. During it, only select pin d is pulled low by hardware, so cs_out = ~(1<<d) when the port register holds FFh.
- R4: Bit d of the length register chooses 16 bits (1) or 8 bits (0) for device d. In a 16-bit transfer the first byte leaves before the second byte (address 00h), and both go MSB first.
- R5: Bit d of the polarity register chooses the clock phase. With 0, sk rests low, input is sampled on the rising edge and so_out changes on the falling edge. With 1, everything is inverted and sk rests high.
- R6: The rate field (address 0Dh, bits [2:0] = n) sets the serial clock period to 2^n input clocks for n ≥ 1, with a floor of 2 clocks for n = 0. Each half period therefore lasts h = max(1, 2^(n-1)) clocks.
- R7: Counting from the clock edge that takes the starting write, the select goes low after 4h clocks. The first sk edge comes after 5h clocks, and the select is released and done is set after (5 + 2N)h clocks, where N is the bit count.
- R8: At completion status bit 7 reads 1 and so_oe drops to 0. irq equals the done bit ANDed with bit 7 of address 0Dh.
- R9: Received bits replace the sent bits. The first byte reads back at 01h and at 02h–09h, and the second byte reads back at 00h.
- R10: While a transfer is running, writes to addresses 00h–09h have no effect, either on the data being shifted out or on the received data read back afterwards.
- R11: The port register (0Ah) drives cs_out = port AND NOT hardware-select. The direction register (0Fh, reset FFh) sets bit = 1 for input, and cs_oe = ~direction. Reading 0Ah returns 1 for output pins and the cs_in level for input pins.
- R12: With bit 6 of address 0Dh set, received bits are taken from so_in instead of si and so_oe stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, also the source of the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| sk | output | 1 | Serial clock |
| so_out | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for the data-out pin |
| so_in | input | 1 | Level on the data-out pin when it is used as input |
| si | input | 1 | Serial data in |
| cs_out | output | 8 | Select pin drive levels (active low) |
| cs_oe | output | 8 | Select pin output enables |
| cs_in | input | 8 | Select pin levels as read back |
| irq | output | 1 | Completion interrupt |

## Verification
Errors inside the sequencer show up at the serial pins within one half period. A wrong step count moves the select fall, the first clock edge or the done rise off their computed cycles. A bad shift path corrupts the captured word that the peripheral model sees or the value read back from the data registers. A stale device or polarity latch shows as the wrong select pin going low, or as bits sampled on the wrong edge. Because done, so_oe and irq all follow the end of the sequence, a lost or extra edge shows up as a late or early interrupt rise against the predicted cycle.

// File: rtl/uwire_ctrl.sv
module uwire_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       sk,
  output logic       so_out,
  output logic       so_oe,
  input  logic       so_in,
  input  logic       si,
  output logic [7:0] cs_out,
  output logic [7:0] cs_oe,
  input  logic [7:0] cs_in,
  output logic       irq
);
  logic [7:0] fmb, smb, port, pol, len, dir;
  logic [2:0] rate_n, dev;
  logic       inten, soi, done, busy, auto_m, pol_l, len_l, ph, rxb, sel_on;
  logic [6:0] half_l, div, hcalc;
  logic [5:0] step, last_step;
  logic       start, tick;
  logic [2:0] sdev;

  assign start     = reg_wr && !busy && reg_addr >= 4'd1 && reg_addr <= 4'd9;
  assign sdev      = (reg_addr == 4'd1) ? 3'd7 : 3'(reg_addr - 4'd2);
  assign hcalc     = (rate_n == 3'd0) ? 7'd1 : (7'd1 << (rate_n - 3'd1));
  assign tick      = busy && (div == half_l - 7'd1);
  assign last_step = len_l ? 6'd36 : 6'd20;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmb <= '0; smb <= '0; port <= 8'hFF; pol <= '0; len <= '0; dir <= 8'hFF;
      rate_n <= '0; inten <= 1'b0; soi <= 1'b0;
      done <= 1'b1; busy <= 1'b0; auto_m <= 1'b0; dev <= '0;
      pol_l <= 1'b0; len_l <= 1'b0; half_l <= 7'd1; div <= '0; step <= '0;
      ph <= 1'b0; rxb <= 1'b0; sel_on <= 1'b0;
    end else begin
      if (reg_wr)
        case (reg_addr)
          4'hA: port <= reg_wdata;
          4'hB: pol  <= reg_wdata;
          4'hC: len  <= reg_wdata;
          4'hD: begin inten <= reg_wdata[7]; soi <= reg_wdata[6]; rate_n <= reg_wdata[2:0]; end
          4'hF: dir  <= reg_wdata;
          default: ;
        endcase
      if (reg_wr && !busy && reg_addr == 4'd0) smb <= reg_wdata;
      if (start) begin
        fmb    <= reg_wdata;
        busy   <= 1'b1;
        done   <= 1'b0;
        auto_m <= (reg_addr != 4'd1);
        dev    <= sdev;
        pol_l  <= pol[sdev];
        len_l  <= len[sdev];
        half_l <= hcalc;
        div    <= '0;
        step   <= '0;
        ph     <= 1'b0;
      end else if (busy) begin
        div <= tick ? 7'd0 : div + 7'd1;
        if (tick) begin
          step <= step + 6'd1;
          if (step == 6'd3 && auto_m) sel_on <= 1'b1;
          if (step >= 6'd4 && step < last_step) begin
            if (!step[0]) begin
              ph  <= 1'b1;
              rxb <= soi ? so_in : si;
            end else begin
              ph <= 1'b0;
              if (len_l) {fmb, smb} <= {fmb[6:0], smb, rxb};
              else       fmb        <= {fmb[6:0], rxb};
            end
          end
          if (step == last_step) begin
            busy   <= 1'b0;
            done   <= 1'b1;
            sel_on <= 1'b0;
          end
        end
      end
    end
  end

  assign sk     = pol_l ^ ph;
  assign so_out = fmb[7];
  assign so_oe  = busy && !soi;
  assign cs_out = port & ~(sel_on ? (8'd1 << dev) : 8'd0);
  assign cs_oe  = ~dir;
  assign irq    = done && inten;

  always_comb begin
    case (reg_addr)
      4'h0:    reg_rdata = smb;
      4'hA:    reg_rdata = (cs_in & dir) | ~dir;
      4'hE:    reg_rdata = {done, 7'd0};
      4'hB, 4'hC, 4'hD, 4'hF: reg_rdata = 8'd0;
      default: reg_rdata = fmb;
    endcase
  end
endmodule

// File: rtl/uwire_ctrl_chk.sv
module uwire_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [3:0] reg_addr,
  input logic       busy,
  input logic       done,
  input logic       sel_on,
  input logic       len_l,
  input logic [7:0] smb,
  input logic       sk,
  input logic       pol_l,
  input logic       so_oe,
  input logic       irq,
  input logic       soi
);
  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !busy && reg_addr >= 4'd1 && reg_addr <= 4'd9) |=> (busy && !done));
  assert_select_in_xfer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_on |-> busy);
  assert_sk_rest_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sk == pol_l));
  assert_done_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !so_oe);
  assert_irq_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done);
  assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !len_l && reg_wr && reg_addr == 4'd0) |=> $stable(smb));
  assert_so_input_R12: assert property (@(posedge clk) disable iff (!rst_n)
    soi |-> !so_oe);
endmodule

bind uwire_ctrl uwire_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .busy(busy), .done(done), .sel_on(sel_on), .len_l(len_l), .smb(smb),
  .sk(sk), .pol_l(pol_l), .so_oe(so_oe), .irq(irq), .soi(soi)
);

// File: tb/uwire_ctrl_tb.sv
`timescale 1ns/1ps
module uwire_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] reg_addr = '0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic sk, so_out, so_oe, so_in, si, irq;
  logic [7:0] cs_out, cs_oe, cs_in = 8'h3C;

  typedef struct {
    int nb; logic [15:0] tx; logic [15:0] resp; bit pol; int dev; bit chk_cs; int h; longint c0;
  } item_t;
  item_t exp_q[$];

  int checks = 0, fails = 0;
  longint cyc = 0;
  logic [15:0] resp = '0;
  int nb = 8, rcnt = 0;
  bit use_so_in = 0, finished = 0;
  logic pbit;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign pbit  = (rcnt < nb) ? resp[nb-1-rcnt] : 1'b0;
  assign si    = use_so_in ? ~pbit : pbit;
  assign so_in = pbit;

  uwire_ctrl u_dut (.*);

  task automatic chk(bit ok, string tag, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] expv, input string tag);
    @(negedge clk); reg_addr = a; #1;
    chk(reg_rdata === expv, tag, reg_rdata, expv);
  endtask

  // Starts a transfer, checks the first cycle, optionally disturbs it, waits, reads back.
  task automatic xfer(input logic [3:0] a, input int n, input logic [15:0] tx, input logic [15:0] rsp,
                      input bit p, input int dev, input bit ccs, input int h, input bit soi_m, input bit disturb);
    item_t it;
    logic exp_msb;
    if (n == 16) wr(4'h0, tx[7:0]);
    resp = rsp; nb = n; use_so_in = soi_m;
    @(negedge clk); reg_addr = a; reg_wdata = (n == 16) ? tx[15:8] : tx[7:0]; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    it.nb = n; it.tx = tx; it.resp = rsp; it.pol = p; it.dev = dev; it.chk_cs = ccs; it.h = h; it.c0 = cyc;
    exp_q.push_back(it);
    exp_msb = (n == 16) ? tx[15] : tx[7];
    chk(so_out === exp_msb, "R2 msb on so_out", so_out, exp_msb);
    chk(so_oe === !soi_m, "R2/R12 so_oe at start", so_oe, !soi_m);
    chk(sk === p, "R5 sk rest level", sk, p);
    reg_addr = 4'hE; #1;
    chk(reg_rdata[7] === 1'b0, "R2 done cleared", reg_rdata[7], 0);
    if (disturb) begin
      wr(4'h0, 8'h55); wr(4'h1, 8'hAA); wr(4'h4, 8'h99);   // R10
    end
    while (!irq) @(negedge clk);
    @(negedge clk);
    chk(so_oe === 1'b0, "R8 so_oe off after done", so_oe, 0);
    rd(4'hE, 8'h80, "R8 status done");
    if (n == 16) begin
      rd(a, rsp[15:8], "R9 first byte readback");
      rd(4'h0, rsp[7:0], "R9 second byte readback");
    end else rd(a, rsp[7:0], "R9 first byte readback");
  endtask

  // Monitor: peripheral side of the scoreboard
  logic prev_sk = 1'b0, prev_irq = 1'b0;
  logic [7:0] prev_cs = 8'hFF, csp = 8'hFF;
  logic [15:0] cap = '0;
  int nsamp = 0;
  longint t_first = -1, t_csf = -1;
  always @(negedge clk) begin
    if (rst_n && exp_q.size() > 0) begin
      item_t c;
      c = exp_q[0];
      if (sk !== prev_sk && sk !== c.pol) begin
        cap = {cap[14:0], so_out};
        nsamp++;
        rcnt++;
        if (nsamp == 1) t_first = cyc;
      end
      if (c.chk_cs && c.dev < 8 && prev_cs[c.dev] && !cs_out[c.dev]) begin
        t_csf = cyc; csp = cs_out;
      end
      if (irq && !prev_irq) begin
        longint edn;
        edn = c.c0 + (5 + 2*c.nb) * c.h;
        chk(nsamp == c.nb, "R4 bit count", nsamp, c.nb);
        chk((c.nb == 16 ? cap : {8'd0, cap[7:0]}) === c.tx, "R4/R5 bits seen by peripheral", cap, c.tx);
        chk(t_first == c.c0 + 5*c.h, "R6/R7 first sk edge cycle", t_first, c.c0 + 5*c.h);
        chk(cyc == edn, "R7/R8 done cycle", cyc, edn);
        if (c.chk_cs) begin
          chk(t_csf == c.c0 + 4*c.h, "R7 select fall cycle", t_csf, c.c0 + 4*c.h);
          chk(csp === ~(8'd1 << c.dev), "R3 only target select low", csp, ~(8'd1 << c.dev));
          chk(cs_out[c.dev] === 1'b1, "R7 select released", cs_out[c.dev], 1);
        end
        void'(exp_q.pop_front());
        nsamp = 0; rcnt = 0; cap = '0; t_first = -1; t_csf = -1;
      end
    end
    prev_sk = sk; prev_irq = irq; prev_cs = cs_out;
  end

  initial begin
    #(8 * 150000);
    chk(0, "watchdog expired", 0, 1);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(4'hE, 8'h80, "R1 status after reset");
    chk(cs_oe === 8'h00, "R1 select pins inputs", cs_oe, 0);
    chk(irq === 1'b0, "R1 irq low", irq, 0);
    rd(4'hA, 8'h3C, "R11 input pins read cs_in");
    // default polarity/length 0: plain transfer is 8-bit, rising-edge sample (R1)
    wr(4'hD, 8'h80);
    xfer(4'h1, 8, 16'h0096, 16'h0069, 0, 8, 0, 1, 0, 0);   // R1 R2
    // configure devices
    wr(4'hF, 8'h00); wr(4'hA, 8'hFF);
    wr(4'hC, 8'h08); wr(4'hB, 8'h08);
    rd(4'hA, 8'hFF, "R11 output pins read 1");
    chk(cs_oe === 8'hFF, "R11 cs_oe follows direction", cs_oe, 8'hFF);
    // R3 R7 auto 8-bit dev0, h=1
    xfer(4'h2, 8, 16'h00A5, 16'h003C, 0, 0, 1, 1, 0, 0);
    // R4 R5 R6 auto 16-bit dev3, pol 1, n=2 -> h=2
    wr(4'hD, 8'h82);
    xfer(4'h5, 16, 16'h1234, 16'hBEEF, 1, 3, 1, 2, 0, 0);
    // R2 R10 R11 plain mode, device-7 settings 16-bit, n=3 -> h=4, software select
    wr(4'hC, 8'h88); wr(4'hB, 8'h08); wr(4'hD, 8'h83); wr(4'hA, 8'hFD);
    chk(cs_out === 8'hFD, "R11 port drives select", cs_out, 8'hFD);
    xfer(4'h1, 16, 16'hC0DE, 16'h5A3C, 0, 8, 0, 4, 0, 1);
    chk(cs_out === 8'hFD, "R2 plain mode keeps software select", cs_out, 8'hFD);
    wr(4'hA, 8'hFF);
    // R12 so as input, n=1 -> h=1, dev2 8-bit
    wr(4'hD, 8'hC1);
    xfer(4'h4, 8, 16'h00F0, 16'h00C3, 0, 2, 1, 1, 1, 0);
    wr(4'hD, 8'h80);
    // R11 override: port bit0 low keeps pin low past the hardware release
    wr(4'hA, 8'hFE);
    xfer(4'h2, 8, 16'h0011, 16'h0077, 0, 0, 0, 1, 0, 0);
    chk(cs_out[0] === 1'b0, "R11 port low overrides release", cs_out[0], 0);
    wr(4'hA, 8'hFF);
    // R8 interrupt mask
    wr(4'hD, 8'h00);
    @(negedge clk);
    chk(irq === 1'b0, "R8 irq masked", irq, 0);
    rd(4'hE, 8'h80, "R8 done still set when masked");
    // R11 mixed direction
    wr(4'hF, 8'h0F); cs_in = 8'hA5;
    rd(4'hA, 8'hF5, "R11 mixed pin read");
    chk(cs_oe === 8'hF0, "R11 cs_oe mixed", cs_oe, 8'hF0);
    chk(exp_q.size() == 0, "R8 all transfers completed", exp_q.size(), 0);
    report();
  end
endmodule